// File: doc/BRIEF.md
# Multi-Mode 24-Bit Serial Command Port

This block is the slave side of a four-wire serial command link. An active-low frame strobe (`syncN`) brackets each transfer. Data bits arrive on `din` and are taken on the falling edge of `sclk`. Each complete 24-bit command either writes a field of a channel register or asks for a register to be read back. All pins are oversampled by the system clock `clk`, so `sclk` must run well below `clk`.

The port has two static modes, chosen by `daisyEn`. In the standalone mode, a command takes effect as soon as its 24th bit has been taken. In the chained mode, the device keeps the last 24 bits of a frame when the frame closes. During the next frame it passes the word it holds out on `sdo`, so a 48-bit frame can load two cascaded devices. In both modes a command with its read flag set arms a readback. The next frame then shifts an echo of the chosen register out on `sdo`, and its own input bits are discarded. Every write produces a one-cycle strobe carrying address, selector and data, together with a low pulse on `busyN`. The register file sits outside the block and is reached through the `rdAddr`/`rdSel`/`rdData` read port.

Top module: `serport`

## Requirements
- R1: A frame is the set of `sclk` falling edges seen while `syncN` is low. Bits enter MSB first. In the 24-bit command, bit 23 is the read flag (1 = read), bits 22:17 are the channel address, bits 16:15 are the register selector, bits 14:12 are ignored and bits 11:0 are the data.
- R2: In the standalone mode (`daisyEn` = 0), a write command gives exactly one `wrValid` pulse carrying its address, selector and data, shortly after the 24th falling edge. Any further bits in the same frame are ignored.
- R3: `busyN` goes low in the same cycle as each `wrValid` pulse and stays low for BUSY_CYCLES clocks.
- R4: A frame that closes with fewer than 24 bits causes no write and arms no readback, in either mode.
- R5: In the chained mode (`daisyEn` = 1), the last 24 bits of a frame of at least 24 bits are committed when `syncN` rises.
- R6: In the chained mode, `sdo` shifts out, MSB first, the word held when the frame began. It advances after each `sclk` rising edge, so each device delays the stream by 24 bits.
- R7: A command with the read flag set causes no write. It latches its address and selector onto `rdAddr` and `rdSel`.
- R8: The next accepted frame after R7 shifts out {1, address, selector, 000, rdData} MSB first on `sdo`. The input bits of that frame are never committed.
- R9: While a readback is armed, a frame whose `syncN` fall comes fewer than RB_IDLE_MIN clocks after `syncN` last went high is dropped whole. It makes no write and drives no `sdo`, and the readback stays armed.
- R10: `sdoOe` is high only inside an accepted frame, and only in the chained mode or in a readback frame.
- R11: After reset, `busyN` = 1, `wrValid` = 0, `sdoOe` = 0 and no readback is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| daisyEn | input | 1 | Static mode select: 1 = chained, 0 = standalone |
| syncN | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial bit clock, idle high |
| din | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo` |
| wrValid | output | 1 | One-cycle write strobe |
| wrAddr | output | 6 | Channel address of the write |
| wrSel | output | 2 | Register selector of the write |
| wrData | output | 12 | Data of the write |
| busyN | output | 1 | Active-low busy pulse following a write |
| rdAddr | output | 6 | Read-port address, latched by a read command |
| rdSel | output | 2 | Read-port selector, latched by a read command |
| rdData | input | 12 | Read-port data from the register file |

## Verification
In the chained mode, the commit of a frame falls in the same cycle as the `syncN` rising edge that closes it. When that frame is a read command, the arming of the readback and the end of the frame land together. The bench provokes this by sending a read command with `daisyEn` set. It then judges the outcome by the `sdo` stream of the following frame, which must carry the register echo and no write. A second overlap, between an arm and an early restart, is provoked by opening a frame only four clocks after the arming frame. That frame must leave no trace, and the echo must still appear on the next well-spaced frame.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 6;
  localparam int SEL_W      = 2;
  localparam int DATA_W     = 12;
  localparam int PAD_W      = FRAME_BITS - 1 - ADDR_W - SEL_W - DATA_W;

  typedef struct packed {
    logic              isRead;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic frameStart;
    logic loadRb;
    logic sampleBit;
    logic driveBit;
    logic latchRb;
  } strobe_t;

  function automatic logic [FRAME_BITS-1:0] packEcho(
    input logic [ADDR_W-1:0] addr,
    input logic [SEL_W-1:0]  sel,
    input logic [DATA_W-1:0] data
  );
    return {1'b1, addr, sel, {PAD_W{1'b0}}, data};
  endfunction
endpackage

// File: rtl/serport_dp.sv
module serport_dp
  import serport_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              din,
  input  logic [DATA_W-1:0] rdData,
  output cmd_t              cmd,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdoBit,
  output logic [ADDR_W-1:0] rbAddr,
  output logic [SEL_W-1:0]  rbSel
);
  localparam int MSB = FRAME_BITS - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] echoWord;

  assign echoWord = packEcho(rbAddr, rbSel, rdData);

  always_comb begin
    cmd.isRead = shiftReg[MSB];
    cmd.addr   = shiftReg[MSB-1 -: ADDR_W];
    cmd.sel    = shiftReg[MSB-1-ADDR_W -: SEL_W];
    cmd.data   = shiftReg[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      sdoBit   <= 1'b0;
      rbAddr   <= '0;
      rbSel    <= '0;
    end else begin
      if (stb.frameStart) begin
        bitCnt <= '0;
        if (stb.loadRb) shiftReg <= echoWord;
        sdoBit <= stb.loadRb ? echoWord[MSB] : shiftReg[MSB];
      end else begin
        if (stb.sampleBit) begin
          shiftReg <= {shiftReg[MSB-1:0], din};
          if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
        end
        if (stb.driveBit) sdoBit <= shiftReg[MSB];
      end
      if (stb.latchRb) begin
        rbAddr <= cmd.addr;
        rbSel  <= cmd.sel;
      end
    end
  end

  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStart |=> (bitCnt == '0));

endmodule

// File: rtl/serport_ctl.sv
module serport_ctl
  import serport_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RB_IDLE_MIN = 16,
  parameter int CNT_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              daisyEn,
  input  logic              syncN,
  input  logic              sclk,
  input  cmd_t              cmd,
  input  logic [CNT_W-1:0]  bitCnt,
  output strobe_t           stb,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [SEL_W-1:0]  wrSel,
  output logic [DATA_W-1:0] wrData,
  output logic              busyN,
  output logic              sdoOe
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int IDLE_W = $clog2(RB_IDLE_MIN + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM  = IDLE_W'(RB_IDLE_MIN);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(FRAME_BITS);

  logic syncQ, sclkQ, sampledQ;
  logic inFrame, rbFrame, rbPending;
  logic [IDLE_W-1:0] idleCnt;
  logic [BUSY_W-1:0] busyCnt;

  logic syncFall, syncRise, sclkFall, sclkRise;
  logic tooSoon, accept, commit, doWrite, doArm;

  always_comb begin
    syncFall = syncQ & ~syncN;
    syncRise = ~syncQ & syncN;
    sclkFall = inFrame & ~syncN & sclkQ & ~sclk;
    sclkRise = inFrame & ~syncN & ~sclkQ & sclk;
    tooSoon  = rbPending && (idleCnt < IDLE_LIM);
    accept   = syncFall && !tooSoon;
    if (daisyEn) commit = inFrame && syncRise && (bitCnt >= FULL_CNT);
    else         commit = inFrame && sampledQ && (bitCnt == FULL_CNT);
    doWrite  = commit && !rbFrame && !cmd.isRead;
    doArm    = commit && !rbFrame && cmd.isRead;
    stb.frameStart = accept;
    stb.loadRb     = accept && rbPending;
    stb.sampleBit  = sclkFall;
    stb.driveBit   = sclkRise;
    stb.latchRb    = doArm;
  end

  assign busyN = (busyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= 1'b1;
      sclkQ     <= 1'b1;
      sampledQ  <= 1'b0;
      inFrame   <= 1'b0;
      rbFrame   <= 1'b0;
      rbPending <= 1'b0;
      idleCnt   <= '0;
      busyCnt   <= '0;
      sdoOe     <= 1'b0;
      wrValid   <= 1'b0;
      wrAddr    <= '0;
      wrSel     <= '0;
      wrData    <= '0;
    end else begin
      syncQ    <= syncN;
      sclkQ    <= sclk;
      sampledQ <= sclkFall;

      if (accept) begin
        inFrame   <= 1'b1;
        rbFrame   <= rbPending;
        rbPending <= 1'b0;
        sdoOe     <= daisyEn || rbPending;
      end else if (syncRise) begin
        inFrame <= 1'b0;
        rbFrame <= 1'b0;
        sdoOe   <= 1'b0;
      end
      if (doArm) rbPending <= 1'b1;

      if (!syncN)                idleCnt <= '0;
      else if (idleCnt != IDLE_LIM) idleCnt <= idleCnt + 1'b1;

      wrValid <= doWrite;
      if (doWrite) begin
        wrAddr  <= cmd.addr;
        wrSel   <= cmd.sel;
        wrData  <= cmd.data;
        busyCnt <= BUSY_LOAD;
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // R10
  oe_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !$past(syncN));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> wrValid);

  // R4
  full_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ($past(bitCnt) >= FULL_CNT));

  // R2
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

endmodule

// File: rtl/serport.sv
module serport
  import serport_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RB_IDLE_MIN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        daisyEn,
  input  logic        syncN,
  input  logic        sclk,
  input  logic        din,
  output logic        sdo,
  output logic        sdoOe,
  output logic        wrValid,
  output logic [5:0]  wrAddr,
  output logic [1:0]  wrSel,
  output logic [11:0] wrData,
  output logic        busyN,
  output logic [5:0]  rdAddr,
  output logic [1:0]  rdSel,
  input  logic [11:0] rdData
);
  localparam int CNT_W = $clog2(2 * FRAME_BITS + 1);

  strobe_t          stb;
  cmd_t             cmd;
  logic [CNT_W-1:0] bitCnt;

  serport_ctl #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .RB_IDLE_MIN(RB_IDLE_MIN),
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .daisyEn(daisyEn), .syncN(syncN), .sclk(sclk),
    .cmd(cmd), .bitCnt(bitCnt), .stb(stb),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrSel(wrSel), .wrData(wrData),
    .busyN(busyN), .sdoOe(sdoOe)
  );

  serport_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .din(din), .rdData(rdData),
    .cmd(cmd), .bitCnt(bitCnt), .sdoBit(sdo),
    .rbAddr(rdAddr), .rbSel(rdSel)
  );

endmodule

// File: tb/serport_bench.sv
module serport_bench;
  localparam int BUSY_CYCLES = 4;
  localparam int RB_IDLE_MIN = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic daisyEn = 1'b0;
  logic syncN = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic sdo, sdoOe, wrValid, busyN;
  logic [5:0] wrAddr, rdAddr;
  logic [1:0] wrSel, rdSel;
  logic [11:0] wrData, rdData;

  int checks = 0;
  int errors = 0;
  int lowRun = 0;
  bit finished = 1'b0;
  logic [19:0] expQ[$];

  always #4 clk = ~clk;

  function automatic logic [11:0] rdModel(input logic [5:0] a, input logic [1:0] s);
    return {s, 4'hA, a};
  endfunction

  assign rdData = rdModel(rdAddr, rdSel);

  serport #(.BUSY_CYCLES(BUSY_CYCLES), .RB_IDLE_MIN(RB_IDLE_MIN)) u_serport (
    .clk(clk), .rstN(rstN), .daisyEn(daisyEn), .syncN(syncN), .sclk(sclk),
    .din(din), .sdo(sdo), .sdoOe(sdoOe), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrSel(wrSel), .wrData(wrData), .busyN(busyN), .rdAddr(rdAddr),
    .rdSel(rdSel), .rdData(rdData)
  );

  function automatic logic [23:0] mk(input logic rd, input logic [5:0] a,
                                     input logic [1:0] s, input logic [2:0] pad,
                                     input logic [11:0] d);
    return {rd, a, s, pad, d};
  endfunction

  function automatic logic [23:0] echo(input logic [5:0] a, input logic [1:0] s);
    return {1'b1, a, s, 3'b000, rdModel(a, s)};
  endfunction

  task automatic checkEq(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushWrite(input logic [23:0] w);
    expQ.push_back({w[22:17], w[16:15], w[11:0]});
  endtask

  task automatic runFrame(input int nBits, input logic [47:0] bits,
                          output logic [47:0] seen, output logic oeMid);
    seen = '0;
    oeMid = 1'b0;
    syncN = 1'b0;
    tick(4);
    for (int i = nBits - 1; i >= 0; i--) begin
      din = bits[i];
      tick(1);
      seen[i] = sdo;
      sclk = 1'b0;
      tick(2);
      if (i == nBits / 2) oeMid = sdoOe;
      tick(2);
      sclk = 1'b1;
      tick(3);
    end
    tick(2);
    syncN = 1'b1;
  endtask

  // scoreboard monitor for write strobes (R2, R3, R5)
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R4 unexpected write actual=%0h expected=none",
                 {wrAddr, wrSel, wrData});
      end else begin
        checkEq("R2 write fields", {wrAddr, wrSel, wrData}, expQ.pop_front());
        checkEq("R3 busy low at strobe", busyN, 1'b0);
      end
    end
  end

  // R3 busy width monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!busyN) lowRun++;
      else if (lowRun > 0) begin
        checkEq("R3 busy width", lowRun, BUSY_CYCLES);
        lowRun = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] seen;
    logic oe;
    logic [23:0] w, a, b, c;

    tick(5);
    // R11 reset state
    checkEq("R11 busyN after reset", busyN, 1'b1);
    checkEq("R11 wrValid after reset", wrValid, 1'b0);
    checkEq("R11 sdoOe after reset", sdoOe, 1'b0);
    rstN = 1'b1;
    tick(3);

    // R1 R2 standalone writes, pad bits ignored
    w = mk(0, 6'd5, 2'd0, 3'b000, 12'h123); pushWrite(w);
    runFrame(24, {24'h0, w}, seen, oe); tick(6);
    checkEq("R10 no oe in standalone write", oe, 1'b0);
    w = mk(0, 6'd63, 2'd3, 3'b111, 12'hFFF); pushWrite(w);
    runFrame(24, {24'h0, w}, seen, oe); tick(6);
    w = mk(0, 6'd0, 2'd2, 3'b000, 12'h000); pushWrite(w);
    runFrame(24, {24'h0, w}, seen, oe); tick(6);
    w = mk(0, 6'd42, 2'd1, 3'b101, 12'hA5A); pushWrite(w);
    runFrame(24, {24'h0, w}, seen, oe); tick(6);

    // R2 extra bits after the 24th are ignored
    w = mk(0, 6'd7, 2'd1, 3'b000, 12'h777); pushWrite(w);
    runFrame(30, {18'h0, w, 6'b101101}, seen, oe); tick(6);

    // R4 short frame discarded
    runFrame(10, 48'h2AB, seen, oe); tick(6);

    // R7 read command arms readback
    runFrame(24, {24'h0, mk(1, 6'd9, 2'd2, 3'b000, 12'h000)}, seen, oe);
    tick(2);
    checkEq("R7 rdAddr latched", rdAddr, 6'd9);
    checkEq("R7 rdSel latched", rdSel, 2'd2);
    tick(40);
    // R8 readback frame, its own write word is not committed
    runFrame(24, {24'h0, mk(0, 6'd1, 2'd0, 3'b000, 12'h055)}, seen, oe);
    tick(6);
    checkEq("R8 readback echo", seen[23:0], echo(6'd9, 2'd2));
    checkEq("R10 oe in readback frame", oe, 1'b1);

    // R9 early frame dropped, arm kept
    runFrame(24, {24'h0, mk(1, 6'd17, 2'd3, 3'b000, 12'h000)}, seen, oe);
    tick(4);
    runFrame(24, {24'h0, mk(0, 6'd3, 2'd0, 3'b000, 12'h111)}, seen, oe);
    checkEq("R9 early frame no oe", oe, 1'b0);
    tick(40);
    runFrame(24, {24'h0, mk(0, 6'd4, 2'd0, 3'b000, 12'h222)}, seen, oe);
    tick(6);
    checkEq("R9 arm kept echo", seen[23:0], echo(6'd17, 2'd3));

    // standalone write works again after readback
    w = mk(0, 6'd20, 2'd2, 3'b000, 12'h3C3); pushWrite(w);
    runFrame(24, {24'h0, w}, seen, oe); tick(6);

    // R5 R6 chained mode
    daisyEn = 1'b1;
    tick(4);
    a = mk(0, 6'd10, 2'd0, 3'b000, 12'h0AA);
    b = mk(0, 6'd11, 2'd1, 3'b000, 12'h0BB);
    pushWrite(b);
    runFrame(48, {a, b}, seen, oe); tick(6);
    checkEq("R6 chained pass-through", seen[23:0], a);
    checkEq("R10 oe in chained frame", oe, 1'b1);
    c = mk(0, 6'd12, 2'd2, 3'b000, 12'hCCC); pushWrite(c);
    runFrame(24, {24'h0, c}, seen, oe); tick(6);
    checkEq("R6 chained held word", seen[23:0], b);

    // R4 chained short frame
    runFrame(20, 48'hABCDE, seen, oe); tick(6);

    // R5 R8 read command committed at frame close in chained mode
    runFrame(24, {24'h0, mk(1, 6'd33, 2'd1, 3'b000, 12'h000)}, seen, oe);
    tick(40);
    runFrame(24, {24'h0, mk(0, 6'd2, 2'd1, 3'b000, 12'h999)}, seen, oe);
    tick(6);
    checkEq("R8 chained readback echo", seen[23:0], echo(6'd33, 2'd1));

    tick(20);
    checkEq("R2 all expected writes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule